// File: doc/BRIEF.md
# Doubleword-Granular Dirty Tracker and Write-Back Controller

This block keeps the valid and dirty state of every line in a small data cache. Each line is 32 bytes and carries one dirty flag per aligned 8-byte doubleword. When a line is flushed, only the modified doublewords travel to memory. Store-update events come in from the cache pipeline. Each event carries a line index, per-byte enables, a flag saying whether the bytes were also written to memory, and a flag for a whole-line zeroing store. Fill completions set a line valid and clean.

Three kinds of request start a flush: a line replacement from the fill logic, a software clean, and a software clean-and-invalidate. For each request the block reads the dirty doublewords through a one-cycle-latency read port into the data array. It sends them to memory as a stream of beats, each with its handshake, and pulses a completion signal when the flush is done. A replacement is acknowledged only after its last beat has been accepted, so the fill logic cannot overwrite the line too early. A force-full mode widens any dirtying store to all four doublewords of the line.

Top module: `dw_dirty_flush`

## Requirements
- R1: Each line has four dirty flags. Flag i covers bytes 8i to 8i+7 of the line, and bit k of `st_be` enables byte k.
- R2: A store with `st_thru`=0 sets the flag of every doubleword that has at least one enabled byte. A store with `st_thru`=1 sets no flag.
- R3: While `full_mark`=1, a store that would set any flag sets all four flags of its line. A store that would set none still sets none.
- R4: A store with `st_zero`=1 sets all four flags of its line, whatever `st_be` and `st_thru` are.
- R5: A flush sends one beat for each dirty doubleword, in ascending order. `wb_dw` gives the offset of the beat. `wb_mask` holds the line's flags as they were when the request was accepted. `wb_last` marks the final beat.
- R6: A request on a line with no dirty flag raises `req_done` in the cycle after acceptance. It issues no read and no beat.
- R7: Once a flush has written back a line, all of that line's flags are clear, so a second flush of the line sends no beat.
- R8: `fill_en` sets the line valid and clears its flags. Request kind 2'b10 (clean-and-invalidate) clears the valid bit when it completes. Kinds 2'b00 (replace) and 2'b01 (clean) leave the valid bit unchanged.
- R9: `req_done` rises in the cycle after the last beat is accepted, and never before. This is the acknowledge for a replacement.
- R10: While `wb_ready`=0, a beat holds its data and offset. The beat data is the value `rd_data` returned one cycle after `rd_en` for that line and offset.
- R11: After reset all lines are invalid and clean, `req_ready`=1 and `wb_valid`=0. `req_ready` is high only while the block is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| full_mark | input | 1 | Force-full mode: a dirtying store marks the whole line |
| st_valid | input | 1 | Store-update event |
| st_line | input | IDX_W | Line index of the store |
| st_be | input | NDW*DATA_W/8 | Byte enables within the line |
| st_thru | input | 1 | Bytes were also written to memory |
| st_zero | input | 1 | Whole-line zeroing store (cache only) |
| fill_en | input | 1 | Fill completed for `fill_line` |
| fill_line | input | IDX_W | Line index of the fill |
| req_valid | input | 1 | Flush request |
| req_kind | input | 2 | 00 replace, 01 clean, 10 clean-and-invalidate |
| req_line | input | IDX_W | Line index of the request |
| req_ready | output | 1 | Block is idle and accepts a request |
| req_done | output | 1 | One-cycle completion pulse |
| rd_en | output | 1 | Data array read strobe |
| rd_line | output | IDX_W | Line to read |
| rd_dw | output | OFF_W | Doubleword to read |
| rd_data | input | DATA_W | Read data, one cycle after `rd_en` |
| wb_valid | output | 1 | Write-back beat valid |
| wb_ready | input | 1 | Memory accepts the beat |
| wb_line | output | IDX_W | Line of the beat |
| wb_dw | output | OFF_W | Doubleword offset of the beat |
| wb_data | output | DATA_W | Beat data |
| wb_mask | output | NDW | Dirty flags of the line at acceptance |
| wb_last | output | 1 | Final beat of the flush |
| line_valid | output | LINES | Valid bit of each line |

## Verification
The bench aims at several corner cases. It sends stores whose byte enables touch the first and last byte of a line. A tracker with the wrong byte-to-doubleword mapping would send the wrong offsets or send them out of order. It sends write-through stores, both with force-full mode on and alone; a design that ignored `st_thru` would raise write-back traffic on a clean line. A zeroing store with no byte enabled must still dirty all four doublewords. It throttles `wb_ready` during flushes. A controller that acknowledged a replacement early, or let a beat change under back-pressure, would show a done pulse while beats are still queued, or corrupted data. Repeat flushes and invalidations confirm that flags and valid bits are cleared only where the rules require.

// File: rtl/dw_dirty_flush.sv
module dw_dirty_flush #(
  parameter int LINES  = 8,
  parameter int DATA_W = 64,
  parameter int NDW    = 4,
  localparam int IDX_W = $clog2(LINES),
  localparam int DWB   = DATA_W / 8,
  localparam int BE_W  = NDW * DWB,
  localparam int OFF_W = $clog2(NDW)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              full_mark,
  input  logic              st_valid,
  input  logic [IDX_W-1:0]  st_line,
  input  logic [BE_W-1:0]   st_be,
  input  logic              st_thru,
  input  logic              st_zero,
  input  logic              fill_en,
  input  logic [IDX_W-1:0]  fill_line,
  input  logic              req_valid,
  input  logic [1:0]        req_kind,
  input  logic [IDX_W-1:0]  req_line,
  output logic              req_ready,
  output logic              req_done,
  output logic              rd_en,
  output logic [IDX_W-1:0]  rd_line,
  output logic [OFF_W-1:0]  rd_dw,
  input  logic [DATA_W-1:0] rd_data,
  output logic              wb_valid,
  input  logic              wb_ready,
  output logic [IDX_W-1:0]  wb_line,
  output logic [OFF_W-1:0]  wb_dw,
  output logic [DATA_W-1:0] wb_data,
  output logic [NDW-1:0]    wb_mask,
  output logic              wb_last,
  output logic [LINES-1:0]  line_valid
);

  typedef enum logic [2:0] {S_IDLE, S_RD, S_WT, S_SEND, S_FIN} state_t;

  state_t            state;
  logic [NDW-1:0]    dirty    [LINES];
  logic [NDW-1:0]    dirty_nx [LINES];
  logic [LINES-1:0]  vld, vld_nx;
  logic [NDW-1:0]    pend, snap, st_hit, st_set;
  logic [IDX_W-1:0]  cur;
  logic              inv;
  logic [OFF_W-1:0]  dw_q, first_dw;
  logic [DATA_W-1:0] data_q;

  always_comb begin
    for (int i = 0; i < NDW; i++) st_hit[i] = |st_be[i*DWB +: DWB];
    if (st_zero)      st_set = '1;
    else if (st_thru) st_set = '0;
    else              st_set = st_hit;
    if (full_mark && |st_set) st_set = '1;
  end

  always_comb begin
    first_dw = '0;
    for (int i = NDW-1; i >= 0; i--)
      if (pend[i]) first_dw = OFF_W'(i);
  end

  always_comb begin
    for (int l = 0; l < LINES; l++) begin
      dirty_nx[l] = dirty[l];
      vld_nx[l]   = vld[l];
      if (fill_en && fill_line == IDX_W'(l)) begin
        dirty_nx[l] = '0;
        vld_nx[l]   = 1'b1;
      end
      if (state == S_RD && cur == IDX_W'(l)) dirty_nx[l][first_dw] = 1'b0;
      if (state == S_FIN && inv && cur == IDX_W'(l)) begin
        dirty_nx[l] = '0;
        vld_nx[l]   = 1'b0;
      end
      if (st_valid && st_line == IDX_W'(l)) dirty_nx[l] = dirty_nx[l] | st_set;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int l = 0; l < LINES; l++) dirty[l] <= '0;
      vld <= '0;
    end else begin
      for (int l = 0; l < LINES; l++) dirty[l] <= dirty_nx[l];
      vld <= vld_nx;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= S_IDLE;
      cur    <= '0;
      inv    <= 1'b0;
      snap   <= '0;
      pend   <= '0;
      dw_q   <= '0;
      data_q <= '0;
    end else begin
      case (state)
        S_IDLE: if (req_valid) begin
          cur   <= req_line;
          inv   <= (req_kind == 2'b10);
          snap  <= dirty[req_line];
          pend  <= dirty[req_line];
          state <= (|dirty[req_line]) ? S_RD : S_FIN;
        end
        S_RD: begin
          dw_q           <= first_dw;
          pend[first_dw] <= 1'b0;
          state          <= S_WT;
        end
        S_WT: begin
          data_q <= rd_data;
          state  <= S_SEND;
        end
        S_SEND: if (wb_ready) state <= (pend == '0) ? S_FIN : S_RD;
        default: state <= S_IDLE;
      endcase
    end
  end

  assign req_ready  = (state == S_IDLE);
  assign req_done   = (state == S_FIN);
  assign rd_en      = (state == S_RD);
  assign rd_line    = cur;
  assign rd_dw      = first_dw;
  assign wb_valid   = (state == S_SEND);
  assign wb_line    = cur;
  assign wb_dw      = dw_q;
  assign wb_data    = data_q;
  assign wb_mask    = snap;
  assign wb_last    = (pend == '0);
  assign line_valid = vld;

  AST_BEAT_IN_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid |-> wb_mask[wb_dw]); // R5
  AST_LAST_IS_TOP: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_valid && wb_last) |-> ((wb_mask >> wb_dw) == NDW'(1))); // R5
  AST_HOLD_UNDER_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_valid && !wb_ready) |=> (wb_valid && $stable(wb_data) && $stable(wb_dw))); // R10
  AST_CLEAN_QUICK: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && dirty[req_line] == '0) |=> (req_done && !rd_en)); // R6
  AST_DONE_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_valid && wb_ready && wb_last) |=> req_done); // R9
  AST_INV_DROPS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    (req_done && inv && !(fill_en && fill_line == cur)) |=> !line_valid[$past(cur)]); // R8
  AST_IDLE_NO_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> !wb_valid); // R11

endmodule

// File: tb/sim_dw_dirty_flush.sv
`timescale 1ns/1ps
module sim_dw_dirty_flush;
  localparam int LINES = 8, DATA_W = 64, NDW = 4, IDX_W = 3, BE_W = 32;

  typedef struct packed {
    logic [IDX_W-1:0] line;
    logic [1:0]       dw;
    logic [63:0]      data;
    logic [3:0]       mask;
    logic             last;
  } beat_t;

  logic clk = 0, rst_n = 0;
  logic full_mark = 0, st_valid = 0, st_thru = 0, st_zero = 0;
  logic [IDX_W-1:0] st_line = '0, fill_line = '0, req_line = '0;
  logic [BE_W-1:0] st_be = '0;
  logic fill_en = 0, req_valid = 0;
  logic [1:0] req_kind = '0;
  logic req_ready, req_done, rd_en, wb_valid, wb_last;
  logic wb_ready = 1;
  logic [IDX_W-1:0] rd_line, wb_line;
  logic [1:0] rd_dw, wb_dw;
  logic [63:0] rd_data = '0, wb_data;
  logic [3:0] wb_mask;
  logic [LINES-1:0] line_valid;

  dw_dirty_flush #(.LINES(LINES), .DATA_W(DATA_W), .NDW(NDW)) u0 (.*);

  always #2.5 clk = ~clk;

  int vectors = 0, miscompares = 0, cyc = 0;
  bit stall_mode = 0, finished = 0, prev_stall = 0;
  logic [63:0] prev_data;
  beat_t expq[$];
  beat_t e;
  logic [3:0] mdirty [LINES];
  logic [LINES-1:0] mvalid = '0;

  function automatic logic [63:0] mk(input int l, input int d);
    return {16'hC0DE, 16'(l), 16'(d), 16'hBEEF ^ 16'(l * 7 + d)};
  endfunction

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  always @(posedge clk) rd_data <= rd_en ? mk(rd_line, rd_dw) : 64'h0;
  always @(negedge clk) begin
    cyc++;
    wb_ready = stall_mode ? (cyc % 3 == 0) : 1'b1;
  end

  always @(posedge clk) if (rst_n) begin
    if (prev_stall && wb_valid)
      check(wb_data == prev_data, "R10", "beat changed under stall", wb_data, prev_data);
    prev_stall = wb_valid && !wb_ready;
    prev_data  = wb_data;
    if (wb_valid && wb_ready) begin
      if (expq.size() == 0) check(0, "R5", "unexpected beat dw", 64'(wb_dw), 64'hx);
      else begin
        e = expq.pop_front();
        check(wb_line == e.line && wb_dw == e.dw, "R5", "beat line/offset",
              {wb_line, wb_dw}, {e.line, e.dw});
        check(wb_data == e.data, "R10", "beat data", wb_data, e.data);
        check(wb_mask == e.mask && wb_last == e.last, "R5", "mask/last",
              {wb_mask, wb_last}, {e.mask, e.last});
      end
    end
  end

  task automatic store(input int l, input logic [BE_W-1:0] be, input bit thru, input bit zero);
    logic [3:0] s;
    for (int i = 0; i < 4; i++) s[i] = |be[i*8 +: 8];
    if (zero) s = 4'hF; else if (thru) s = 4'h0;
    if (full_mark && |s) s = 4'hF;
    mdirty[l] |= s;
    @(negedge clk);
    st_valid = 1; st_line = IDX_W'(l); st_be = be; st_thru = thru; st_zero = zero;
    @(negedge clk);
    st_valid = 0; st_be = '0; st_thru = 0; st_zero = 0;
  endtask

  task automatic fill(input int l);
    mdirty[l] = '0; mvalid[l] = 1;
    @(negedge clk);
    fill_en = 1; fill_line = IDX_W'(l);
    @(negedge clk);
    fill_en = 0;
  endtask

  task automatic flush(input logic [1:0] kind, input int l, input string tag);
    logic [3:0] m;
    int n, t;
    m = mdirty[l];
    n = 0;
    for (int d = 0; d < 4; d++) if (m[d]) n++;
    t = 0;
    for (int d = 0; d < 4; d++) if (m[d]) begin
      t++;
      expq.push_back('{line: IDX_W'(l), dw: 2'(d), data: mk(l, d), mask: m, last: (t == n)});
    end
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1; req_kind = kind; req_line = IDX_W'(l);
    @(negedge clk);
    req_valid = 0;
    if (m == 0) begin
      check(req_done == 1 && rd_en == 0, "R6", {tag, " clean line quick done"},
            64'({req_done, rd_en}), 64'h2);
    end else begin
      check(req_ready == 0, "R11", {tag, " busy not ready"}, 64'(req_ready), 64'h0);
      t = 0;
      while (!req_done && t < 200) begin @(negedge clk); t++; end
      check(req_done == 1, "R9", {tag, " done seen"}, 64'(req_done), 64'h1);
      check(expq.size() == 0, "R9", {tag, " done after all beats"}, 64'(expq.size()), 64'h0);
    end
    mdirty[l] = '0;
    if (kind == 2'b10) mvalid[l] = 0;
    @(negedge clk);
    check(line_valid == mvalid, "R8", {tag, " valid bits"}, 64'(line_valid), 64'(mvalid));
  endtask

  initial begin
    #(5.0 * 150000);
    if (!finished) begin
      vectors++; miscompares++;
      $display("FAIL watchdog expired actual=%0d expected=0", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    for (int l = 0; l < LINES; l++) mdirty[l] = '0;
    repeat (4) @(negedge clk);
    check(req_ready == 1 && wb_valid == 0 && req_done == 0 && line_valid == 0, "R11",
          "reset state", {req_ready, wb_valid, req_done, line_valid}, 64'h400);
    rst_n = 1;
    for (int l = 0; l < LINES; l++) fill(l);
    @(negedge clk);
    check(line_valid == 8'hFF, "R8", "fills set valid", 64'(line_valid), 64'hFF);

    // R1 R2: bytes 8..15 dirty only dw1
    store(1, 32'h0000_FF00, 0, 0);
    flush(2'b01, 1, "R1");
    // R2: write-through leaves line clean
    store(2, 32'hFFFF_FFFF, 1, 0);
    flush(2'b01, 2, "R2");
    // R5: first and last byte, ascending under back-pressure
    stall_mode = 1;
    store(3, 32'h8000_0001, 0, 0);
    flush(2'b01, 3, "R5");
    // accumulated stores dw2 then dw0
    store(0, 32'h0001_0000, 0, 0);
    store(0, 32'h0000_0010, 0, 0);
    flush(2'b00, 0, "R9");
    stall_mode = 0;
    // R3: force-full widening, and no effect on write-through
    full_mark = 1;
    store(4, 32'h0001_0000, 0, 0);
    store(5, 32'h0000_00FF, 1, 0);
    full_mark = 0;
    flush(2'b01, 4, "R3");
    flush(2'b01, 5, "R3");
    // R7: second flush of a cleaned line is quiet
    flush(2'b01, 4, "R7");
    // R4: zeroing store with no enables and write-through set
    store(6, 32'h0, 1, 1);
    stall_mode = 1;
    flush(2'b10, 6, "R4");
    stall_mode = 0;
    // R8: clean-invalidate on a clean line, replace on a clean line
    flush(2'b10, 7, "R8");
    flush(2'b00, 1, "R8");
    // R8: refill restores valid and clean state
    fill(6);
    flush(2'b01, 6, "R8");
    // R7: dirty, flush with replace, then confirm clean
    store(5, 32'h0F00_0000, 0, 0);
    flush(2'b00, 5, "R9");
    flush(2'b00, 5, "R7");
    repeat (3) @(negedge clk);
    check(expq.size() == 0, "R5", "no beats left", 64'(expq.size()), 64'h0);
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule